// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block connects a clocked internal requester to an external asynchronous static RAM of 262,144 sixteen-bit words with a byte-lane write mask. The requester offers one request at a time on a valid/ready port. A request carries an 18-bit word address, a read/write flag, 16 bits of write data and one enable bit per byte lane. Read results come back with a single-cycle valid strobe. On the memory side the block drives active-low chip-select, write-strobe and output-gate pins, one active-low strobe per byte lane, and the address. The bidirectional data bus is split into a driven value, a sampled value and a drive enable.

Every memory-facing pin comes from a register. All strobes therefore change on one clock edge and do not glitch. The lengths of the read window and the write pulse are counted in controller clocks and set by parameters. These must be chosen so that the read window covers the memory's address access time and the write pulse meets its minimum width. A write is committed when the write strobe rises. The block then keeps data and address on the bus for one more clock before it releases the driver, and it only starts driving after the memory's output gate has been closed. When no access is in progress, the chip-select is held inactive, which leaves the memory in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and in every cycle with no access in progress, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0 and `req_ready` is 1.
- R2: A request is taken only on a clock edge where both `req_valid` and `req_ready` are 1. `req_ready` is 0 from the cycle after acceptance until the access has ended, and `req_valid` has no effect while `req_ready` is 0.
- R3: An accepted read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1, with `mem_addr` equal to the request address, for exactly RD_CYC clocks. The bus is sampled on the last of those clocks, and `rsp_valid` is 1 for exactly one cycle, the one that follows.
- R4: Lane strobe `mem_bl_n[i]` equals the inverse of `req_be[i]` during the access. Lane 0 covers data bits 7:0 and lane 1 covers bits 15:8.
- R5: An accepted write holds `mem_ce_n`=0, `mem_we_n`=0, `mem_oe_n`=1 and `mem_dq_oe`=1, with `mem_dq_out` equal to the request data, for exactly WR_CYC clocks. The memory stores only the lanes whose enable bit is 1, so a write with both enables at 0 leaves the word unchanged.
- R6: For one clock after `mem_we_n` rises, `mem_dq_oe` stays 1 while `mem_dq_out` and `mem_addr` stay unchanged and `mem_oe_n` stays 1. In the next cycle the driver is off and `req_ready` is 1.
- R7: On a read, each byte lane whose enable bit is 0 returns 0 in `rsp_rdata`, whatever is on that part of the bus.
- R8: `mem_dq_oe` is never 1 in a cycle where `mem_oe_n` is 0. `mem_dq_oe` only goes from 0 to 1 when `mem_oe_n` was 1 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output gate, active low |
| mem_bl_n | output | 2 | Byte-lane strobes, active low |
| mem_dq_out | output | 16 | Data driven towards the memory |
| mem_dq_in | input | 16 | Data sampled from the memory |
| mem_dq_oe | output | 1 | Data driver enable |

## Verification
The bench uses a behavioural memory that drives the bus only when it is selected, gated and not being written, and puts a garbage pattern on every lane it does not drive. A controller that forgot to mask unselected read lanes would return that pattern instead of zero. A write with a single lane enabled, followed by a full-word read, shows whether the strobe polarity or the lane order is swapped, because the wrong byte of the word would change. A design that released the driver on the same edge as the write strobe, or that drove while the output gate was open, is caught by a per-cycle check for both sides driving the bus at once. A request left valid during a busy write must not produce a second write, which a later read of that address reveals.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_HOLD  = 2'd3
   } sram_state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
   import sram_ctrl_pkg::*;
#(
   parameter int RD_CYC = 3,
   parameter int WR_CYC = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        start_wr,
   output sram_state_e state_nxt,
   output logic        idle,
   output logic        rd_last
);

   localparam int MAX_CYC = max2(RD_CYC, WR_CYC);
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   sram_state_e      state_q;
   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             cnt_zero;

   assign cnt_zero = (cnt_q == '0);

   always_comb begin
      state_nxt = state_q;
      cnt_nxt   = cnt_q;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               state_nxt = start_wr ? ST_WRITE : ST_READ;
               cnt_nxt   = start_wr ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
            end
         end
         ST_READ: begin
            if (cnt_zero) state_nxt = ST_IDLE;
            else          cnt_nxt   = cnt_q - 1'b1;
         end
         ST_WRITE: begin
            if (cnt_zero) state_nxt = ST_HOLD;
            else          cnt_nxt   = cnt_q - 1'b1;
         end
         ST_HOLD: state_nxt = ST_IDLE;
         default: state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_nxt;
         cnt_q   <= cnt_nxt;
      end
   end

   assign idle    = (state_q == ST_IDLE);
   assign rd_last = (state_q == ST_READ) && cnt_zero;

endmodule

// File: rtl/sram_ctrl_lane.sv
module sram_ctrl_lane #(
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              en_in,
   input  logic [LANE_W-1:0] wdata_in,
   input  logic              capture,
   input  logic [LANE_W-1:0] bus_in,
   output logic              strobe_n,
   output logic [LANE_W-1:0] wdata_out,
   output logic [LANE_W-1:0] rdata_out
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_n  <= 1'b1;
         wdata_out <= '0;
      end else if (load) begin
         strobe_n  <= ~en_in;
         wdata_out <= wdata_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_out <= '0;
      else if (capture) rdata_out <= strobe_n ? '0 : bus_in;
   end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 16,
   parameter int LANE_W = 8,
   parameter int RD_CYC = 3,
   parameter int WR_CYC = 2,
   localparam int LANES = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [LANES-1:0]  mem_bl_n,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);

   if (LANES * LANE_W != DATA_W) begin : g_bad_lanes
      $error("DATA_W must be a whole number of lanes");
   end
   if (RD_CYC < 1 || WR_CYC < 1) begin : g_bad_cyc
      $error("cycle counts must be at least one");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be positive");
   end

   sram_state_e state_nxt;
   logic        idle, rd_last, accept;

   assign accept    = req_valid && idle;
   assign req_ready = idle;

   sram_ctrl_seq #(
      .RD_CYC (RD_CYC),
      .WR_CYC (WR_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .start_wr  (req_write),
      .state_nxt (state_nxt),
      .idle      (idle),
      .rd_last   (rd_last)
   );

   // pins are registered from the next state so they switch together
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_ce_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
         rsp_valid <= 1'b0;
      end else begin
         mem_ce_n  <= (state_nxt == ST_IDLE);
         mem_we_n  <= (state_nxt != ST_WRITE);
         mem_oe_n  <= (state_nxt != ST_READ);
         mem_dq_oe <= (state_nxt == ST_WRITE) || (state_nxt == ST_HOLD);
         rsp_valid <= rd_last;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_addr <= '0;
      else if (accept) mem_addr <= req_addr;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      sram_ctrl_lane #(
         .LANE_W (LANE_W)
      ) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (accept),
         .en_in     (req_be[i]),
         .wdata_in  (req_wdata[i*LANE_W +: LANE_W]),
         .capture   (rd_last),
         .bus_in    (mem_dq_in[i*LANE_W +: LANE_W]),
         .strobe_n  (mem_bl_n[i]),
         .wdata_out (mem_dq_out[i*LANE_W +: LANE_W]),
         .rdata_out (rsp_rdata[i*LANE_W +: LANE_W])
      );
   end

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic              mem_dq_oe,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic [ADDR_W-1:0] mem_addr
);

   // R1
   idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

   // R2
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R3
   read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_ce_n && mem_we_n));

   // R3
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R5
   write_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

   // R6
   write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_dq_out) && $stable(mem_addr)));

   // R8
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   // R8
   turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> $past(mem_oe_n));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .mem_ce_n   (mem_ce_n),
   .mem_we_n   (mem_we_n),
   .mem_oe_n   (mem_oe_n),
   .mem_dq_oe  (mem_dq_oe),
   .mem_dq_out (mem_dq_out),
   .mem_addr   (mem_addr)
);

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;

   localparam int AW = 18;
   localparam int DW = 16;
   localparam int RD = 3;
   localparam int WR = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    req_be = '0;
   logic          req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
   logic [AW-1:0] mem_addr;
   logic [1:0]    mem_bl_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sram_async_ctrl #(.RD_CYC(RD), .WR_CYC(WR)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_bl_n(mem_bl_n), .mem_dq_out(mem_dq_out),
      .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
   );

   // behavioural memory
   logic [DW-1:0] store [int];
   logic          mdrv;
   logic [DW-1:0] mword;

   assign mdrv  = !mem_ce_n && !mem_oe_n && mem_we_n;
   assign mword = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : '0;
   assign mem_dq_in = mdrv ? {mem_bl_n[1] ? 8'hA5 : mword[15:8],
                              mem_bl_n[0] ? 8'hA5 : mword[7:0]} : 16'hA5A5;

   always @(posedge mem_we_n) begin
      if (rst_n && !mem_ce_n) begin
         logic [DW-1:0] w;
         w = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : '0;
         if (!mem_bl_n[0]) w[7:0]  = mem_dq_out[7:0];
         if (!mem_bl_n[1]) w[15:8] = mem_dq_out[15:8];
         store[int'(mem_addr)] = w;
      end
   end

   // R8: both sides driving in the same cycle
   always @(negedge clk) begin
      if (rst_n && mem_dq_oe && mdrv) begin
         n_bad++;
         $display("FAIL R8 bus contention: dq_oe=%0d mem_drive=%0d expected 0", mem_dq_oe, mdrv);
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic chk_idle(input string tag);
      chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready, tag,
          {27'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 32'h1D);
   endtask

   // fields: write, addr, wdata, be, expected read data
   localparam int NV = 13;
   localparam logic [52:0] VEC [NV] = '{
      {1'b1, 18'h00010, 16'h1234, 2'b11, 16'h0000},
      {1'b0, 18'h00010, 16'h0000, 2'b11, 16'h1234},
      {1'b1, 18'h00010, 16'hABCD, 2'b01, 16'h0000},
      {1'b0, 18'h00010, 16'h0000, 2'b11, 16'h12CD},
      {1'b1, 18'h00010, 16'h9988, 2'b10, 16'h0000},
      {1'b0, 18'h00010, 16'h0000, 2'b11, 16'h99CD},
      {1'b0, 18'h00010, 16'h0000, 2'b01, 16'h00CD},
      {1'b0, 18'h00010, 16'h0000, 2'b10, 16'h9900},
      {1'b1, 18'h3FFFF, 16'hFFFF, 2'b11, 16'h0000},
      {1'b0, 18'h3FFFF, 16'h0000, 2'b11, 16'hFFFF},
      {1'b1, 18'h3FFFF, 16'h0000, 2'b00, 16'h0000},
      {1'b0, 18'h3FFFF, 16'h0000, 2'b11, 16'hFFFF},
      {1'b0, 18'h00000, 16'h0000, 2'b11, 16'h0000}
   };

   // called at a negedge with the controller idle
   task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [1:0] be, input logic [DW-1:0] exp);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      chk(req_ready, "R2 ready before accept", {31'd0, req_ready}, 32'd1);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (wr) begin
         for (int i = 0; i < WR; i++) begin
            if (i > 0) @(negedge clk);
            chk(!mem_ce_n && !mem_we_n && mem_oe_n && mem_dq_oe && !req_ready,
                "R5 write strobes", {28'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 32'h3);
            chk(mem_dq_out == d && mem_addr == a, "R5 write data/addr", {14'd0, mem_dq_out}, {14'd0, d});
            chk(mem_bl_n == ~be, "R4 lane strobes on write", {30'd0, mem_bl_n}, {30'd0, ~be});
         end
         @(negedge clk);
         chk(mem_we_n && mem_dq_oe && mem_oe_n && mem_dq_out == d && !req_ready,
             "R6 hold after strobe", {27'd0, mem_we_n, mem_dq_oe, mem_oe_n, req_ready, 1'b0}, 32'h1C);
         @(negedge clk);
         chk_idle("R6 driver released, ready back");
      end else begin
         for (int i = 0; i < RD; i++) begin
            if (i > 0) @(negedge clk);
            chk(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe && !req_ready && !rsp_valid,
                "R3 read strobes", {28'd0, mem_ce_n, mem_oe_n, mem_we_n, rsp_valid}, 32'h2);
            chk(mem_addr == a, "R3 read address", {14'd0, mem_addr}, {14'd0, a});
            chk(mem_bl_n == ~be, "R4 lane strobes on read", {30'd0, mem_bl_n}, {30'd0, ~be});
         end
         @(negedge clk);
         chk(rsp_valid, "R3 rsp_valid pulse", {31'd0, rsp_valid}, 32'd1);
         chk(rsp_rdata == exp, "R3 R7 read data", {16'd0, rsp_rdata}, {16'd0, exp});
         chk_idle("R1 idle after read");
         @(negedge clk);
         chk(!rsp_valid, "R3 rsp_valid one cycle", {31'd0, rsp_valid}, 32'd0);
      end
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_idle("R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R1 idle after reset");

      for (int v = 0; v < NV; v++) begin
         access(VEC[v][52], VEC[v][51:34], VEC[v][33:18], VEC[v][17:16], VEC[v][15:0]);
         @(negedge clk);
         chk_idle("R1 standby between accesses");
      end

      // R2: a request held valid while busy is ignored
      req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00030;
      req_wdata = 16'h7777; req_be = 2'b11;
      @(posedge clk);
      @(negedge clk);
      req_addr = 18'h00020; req_wdata = 16'h5555;
      for (int i = 0; i < WR + 1; i++) begin
         chk(!req_ready, "R2 ready low while busy", {31'd0, req_ready}, 32'd0);
         if (i < WR) @(negedge clk);
      end
      req_valid = 1'b0;
      @(negedge clk);
      chk_idle("R2 idle after busy write");
      access(1'b0, 18'h00020, 16'h0000, 2'b11, 16'h0000);
      @(negedge clk);
      access(1'b0, 18'h00030, 16'h0000, 2'b11, 16'h7777);

      // R8 read followed directly by a write
      @(negedge clk);
      access(1'b1, 18'h00040, 16'hC3C3, 2'b11, 16'h0000);
      access(1'b0, 18'h00040, 16'h0000, 2'b11, 16'hC3C3);
      finish_run();
   end

endmodule